// File: doc/BRIEF.md
# Legacy-Mode Line Slot Scheduler

This block turns the horizontal slot position of a 32-cell legacy display line into the single memory-access operation the video processor performs in that slot. A tile and sprite video processor uses it to share its video memory port among the host CPU, the sprite pipeline and the background fetcher. The slot map is fixed and irregular. Background columns fill the first part of the line. Sprite work comes in six-slot groups, with CPU windows between them, and the sprite table scan wraps through the end of the line.

The scheduler also latches the horizontal scroll value once per line. When scroll lock is on, that value is forced to zero for the top rows of the screen. It emits two strobes: one clears the sprite line buffer and rewinds the sprite draw index, and the other reinitialises the small background staging buffer. Every output is registered, so each one describes the slot that was presented on the previous clock edge. The slot counter is an input to the block, and it is assumed to advance by one slot per clock.

Top module: `spr_slot_sched`

## Requirements
- R1: With `rst_n` low at a clock edge, every output becomes zero after that edge: `op` = 0 (idle), `col` = 0, `phase` = 0, `hscroll` = 0, and both strobes low.
- R2: Every output reflects the `hslot` sampled at the previous rising edge. Slots 133–136, 234–238, 251 and 252 give `op` = 1 (CPU access).
- R3: Four sprite groups start at slots 137, 143, 239 and 245. Within a group, positions 0 to 5 give `op` = 3 (X read), 3, 4 (pattern fetch), 5 (cell render), 4, 5, and `phase` equals the position.
- R4: Slots 253, 254, 255 and 0 through 4 give `op` = 2 (sprite table scan), with `phase` = 0.
- R5: Slots 5 through 132 give `op` = 6 (background column). `col` = (hslot−5)/4 and `phase` = (hslot−5) mod 4, so column 31 occupies slots 129–132.
- R6: Slots 149 through 233 give `op` = 0 (idle). Outside the column blocks `col` is 0, and outside the sprite and column blocks `phase` is 0.
- R7: At slot 252, `hscroll` loads `xscroll` when no lock applies.
- R8: At slot 252, if `scroll_lock` is 1 and `vcounter` < 16, `hscroll` loads 0. When `vcounter` is 16 or more, the lock has no effect.
- R9: At any slot other than 252, `hscroll` holds its value, and changes on `xscroll` are ignored.
- R10: `lbuf_clr` is high for exactly the cycle after slot 136 is sampled.
- R11: `tbuf_init` is high for exactly the cycle after slot 4 is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hslot | input | 8 | Horizontal slot counter |
| vcounter | input | VC_W (9) | Current line number |
| scroll_lock | input | 1 | Locks horizontal scroll to 0 on the top rows |
| xscroll | input | XS_W (8) | Horizontal scroll register value |
| op | output | 3 | Operation code for the previous slot |
| col | output | 5 | Background column index |
| phase | output | 3 | Position within a sprite group or a column block |
| hscroll | output | XS_W (8) | Latched horizontal scroll |
| lbuf_clr | output | 1 | Sprite line buffer clear and draw index rewind |
| tbuf_init | output | 1 | Background staging buffer init |

## Verification
The bench builds the block with its defaults: a 9-bit line counter, an 8-bit scroll value and a lock region of 16 rows. With those values the lock boundary between lines 15 and 16 can be reached directly, and so can the whole 256-slot space. A full sweep of all 256 slots counts each operation code and compares the totals with the map: 11 CPU slots, 8 scan slots, 8 slots each of X read, fetch and render, 128 column slots and 85 idle slots. The wrap of the scan window through slot 0 and the edges of column 31 are checked directly.

// File: rtl/spr_sched_pkg.sv
// Shared constants and types for the legacy-mode slot scheduler.
// Assumes an 8-bit slot counter; the slot landmarks are fixed by the line timing.
package spr_sched_pkg;

    localparam int SLOT_W    = 8;
    localparam int COLS      = 32;
    localparam int COL_SLOTS = 4;
    localparam int CIDX_W    = $clog2(COLS);
    localparam int CSH       = $clog2(COL_SLOTS);
    localparam int GROUPS    = 4;
    localparam int GRP_LEN   = 6;

    localparam logic [SLOT_W-1:0] COL_BASE   = 8'd5;
    localparam logic [SLOT_W-1:0] COL_LAST   = 8'(5 + COLS*COL_SLOTS - 1);
    localparam logic [SLOT_W-1:0] SCAN_FIRST = 8'd253;
    localparam logic [SLOT_W-1:0] SCAN_LAST  = 8'd4;
    localparam logic [SLOT_W-1:0] LATCH_SLOT = 8'd252;
    localparam logic [SLOT_W-1:0] CLR_SLOT   = 8'd136;

    localparam logic [SLOT_W-1:0] GRP_START [GROUPS] = '{8'd137, 8'd143, 8'd239, 8'd245};

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_CPU    = 3'd1,
        OP_SCAN   = 3'd2,
        OP_SXREAD = 3'd3,
        OP_SFETCH = 3'd4,
        OP_SREND  = 3'd5,
        OP_BGCOL  = 3'd6
    } op_e;

    // Operation for a position inside a six-slot sprite group.
    function automatic op_e grp_op(input logic [2:0] pos);
        case (pos)
            3'd0, 3'd1: grp_op = OP_SXREAD;
            3'd2, 3'd4: grp_op = OP_SFETCH;
            default:    grp_op = OP_SREND;
        endcase
    endfunction

endpackage

// File: rtl/spr_slot_decode.sv
// Combinational slot map: turns one slot number into an operation, a column
// index and a group position. Assumes the fixed 32-cell legacy line layout.
module spr_slot_decode
    import spr_sched_pkg::*;
(
    input  logic [SLOT_W-1:0] hslot,
    output op_e               op,
    output logic [CIDX_W-1:0] col,
    output logic [2:0]        phase
);

    logic [SLOT_W-1:0] col_off;
    logic              in_cols;
    logic              in_scan;
    logic              in_cpu;
    logic [GROUPS-1:0] grp_hit;
    logic [2:0]        grp_pos [GROUPS];

    assign col_off = hslot - COL_BASE;
    assign in_cols = (hslot >= COL_BASE) && (hslot <= COL_LAST);
    assign in_scan = (hslot >= SCAN_FIRST) || (hslot <= SCAN_LAST);
    assign in_cpu  = (hslot >= 8'd133 && hslot <= 8'd136) ||
                     (hslot >= 8'd234 && hslot <= 8'd238) ||
                     (hslot == 8'd251) || (hslot == LATCH_SLOT);

    // One window comparator per sprite group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [SLOT_W-1:0] rel;
        assign rel        = hslot - GRP_START[g];
        assign grp_hit[g] = (rel < 8'(GRP_LEN));
        assign grp_pos[g] = rel[2:0];
    end

    // Priority-free select: the windows never overlap.
    always_comb begin
        op    = OP_IDLE;
        col   = '0;
        phase = '0;
        if (in_cols) begin
            op    = OP_BGCOL;
            col   = col_off[CSH +: CIDX_W];
            phase = 3'(col_off[CSH-1:0]);
        end else if (in_scan) begin
            op = OP_SCAN;
        end else if (in_cpu) begin
            op = OP_CPU;
        end else begin
            for (int g = 0; g < GROUPS; g++) begin
                if (grp_hit[g]) begin
                    op    = grp_op(grp_pos[g]);
                    phase = grp_pos[g];
                end
            end
        end
    end

endmodule

// File: rtl/spr_scroll_latch.sv
// Per-line horizontal scroll latch with top-row lock. Assumes latch_en
// pulses once per line; the value holds between pulses.
module spr_scroll_latch #(
    parameter int VC_W      = 9,
    parameter int XS_W      = 8,
    parameter int LOCK_ROWS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_en,
    input  logic [VC_W-1:0] vcounter,
    input  logic            scroll_lock,
    input  logic [XS_W-1:0] xscroll,
    output logic [XS_W-1:0] hscroll
);

    localparam logic [VC_W-1:0] LOCK_LIM = VC_W'(LOCK_ROWS);

    logic locked;
    assign locked = scroll_lock && (vcounter < LOCK_LIM);

    // Capture the scroll value, forced to zero in the locked region.
    always_ff @(posedge clk) begin
        if (!rst_n)        hscroll <= '0;
        else if (latch_en) hscroll <= locked ? '0 : xscroll;
    end

endmodule

// File: rtl/spr_slot_sched.sv
// Top of the legacy-mode slot scheduler: registers the decoded operation
// and the two buffer strobes, and owns the scroll latch. Assumes hslot
// advances one slot per clock; all outputs lag hslot by one clock.
module spr_slot_sched
    import spr_sched_pkg::*;
#(
    parameter int VC_W      = 9,
    parameter int XS_W      = 8,
    parameter int LOCK_ROWS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] hslot,
    input  logic [VC_W-1:0]   vcounter,
    input  logic              scroll_lock,
    input  logic [XS_W-1:0]   xscroll,
    output logic [2:0]        op,
    output logic [CIDX_W-1:0] col,
    output logic [2:0]        phase,
    output logic [XS_W-1:0]   hscroll,
    output logic              lbuf_clr,
    output logic              tbuf_init
);

    op_e               dec_op;
    logic [CIDX_W-1:0] dec_col;
    logic [2:0]        dec_phase;

    spr_slot_decode u_dec (
        .hslot (hslot),
        .op    (dec_op),
        .col   (dec_col),
        .phase (dec_phase)
    );

    spr_scroll_latch #(
        .VC_W      (VC_W),
        .XS_W      (XS_W),
        .LOCK_ROWS (LOCK_ROWS)
    ) u_scroll (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_en    (hslot == LATCH_SLOT),
        .vcounter    (vcounter),
        .scroll_lock (scroll_lock),
        .xscroll     (xscroll),
        .hscroll     (hscroll)
    );

    // Register the decoded slot and the buffer strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op        <= OP_IDLE;
            col       <= '0;
            phase     <= '0;
            lbuf_clr  <= 1'b0;
            tbuf_init <= 1'b0;
        end else begin
            op        <= dec_op;
            col       <= dec_col;
            phase     <= dec_phase;
            lbuf_clr  <= (hslot == CLR_SLOT);
            tbuf_init <= (hslot == SCAN_LAST);
        end
    end

endmodule

// File: rtl/spr_slot_sched_chk.sv
// Property checker for the slot scheduler, attached by bind.
module spr_slot_sched_chk #(
    parameter int VC_W      = 9,
    parameter int XS_W      = 8,
    parameter int LOCK_ROWS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      hslot,
    input logic [VC_W-1:0] vcounter,
    input logic            scroll_lock,
    input logic [XS_W-1:0] xscroll,
    input logic [2:0]      op,
    input logic [4:0]      col,
    input logic [2:0]      phase,
    input logic [XS_W-1:0] hscroll,
    input logic            lbuf_clr,
    input logic            tbuf_init
);

    a_r2_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ((hslot >= 8'd234 && hslot <= 8'd238) || hslot == 8'd133) |=> (op == 3'd1));

    a_r3_group_start: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot == 8'd239) |=> (op == 3'd3 && phase == 3'd0));

    a_r4_scan_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot == 8'd0) |=> (op == 3'd2));

    a_r5_col_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd6) |-> (phase < 3'd4));

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |-> (col == 5'd0 && phase == 3'd0));

    a_r8_lock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot == 8'd252 && scroll_lock && vcounter < VC_W'(LOCK_ROWS)) |=> (hscroll == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot != 8'd252) |=> $stable(hscroll));

    a_r10_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot != 8'd136) |=> !lbuf_clr);

    a_r11_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hslot == 8'd4) |=> tbuf_init);

endmodule

bind spr_slot_sched spr_slot_sched_chk #(
    .VC_W      (VC_W),
    .XS_W      (XS_W),
    .LOCK_ROWS (LOCK_ROWS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hslot       (hslot),
    .vcounter    (vcounter),
    .scroll_lock (scroll_lock),
    .xscroll     (xscroll),
    .op          (op),
    .col         (col),
    .phase       (phase),
    .hscroll     (hscroll),
    .lbuf_clr    (lbuf_clr),
    .tbuf_init   (tbuf_init)
);

// File: tb/tb_spr_slot_sched.sv
module tb_spr_slot_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hslot = '0;
    logic [8:0] vcounter = '0;
    logic       scroll_lock = 1'b0;
    logic [7:0] xscroll = '0;
    logic [2:0] op;
    logic [4:0] col;
    logic [2:0] phase;
    logic [7:0] hscroll;
    logic       lbuf_clr;
    logic       tbuf_init;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spr_slot_sched dut (
        .clk(clk), .rst_n(rst_n), .hslot(hslot), .vcounter(vcounter),
        .scroll_lock(scroll_lock), .xscroll(xscroll), .op(op), .col(col),
        .phase(phase), .hscroll(hscroll), .lbuf_clr(lbuf_clr), .tbuf_init(tbuf_init)
    );

    // {slot, op, col, phase}
    localparam int NV = 29;
    localparam logic [18:0] VEC [NV] = '{
        {8'd133, 3'd1, 5'd0,  3'd0}, {8'd136, 3'd1, 5'd0,  3'd0},
        {8'd234, 3'd1, 5'd0,  3'd0}, {8'd238, 3'd1, 5'd0,  3'd0},
        {8'd251, 3'd1, 5'd0,  3'd0}, {8'd252, 3'd1, 5'd0,  3'd0},
        {8'd137, 3'd3, 5'd0,  3'd0}, {8'd138, 3'd3, 5'd0,  3'd1},
        {8'd139, 3'd4, 5'd0,  3'd2}, {8'd140, 3'd5, 5'd0,  3'd3},
        {8'd141, 3'd4, 5'd0,  3'd4}, {8'd142, 3'd5, 5'd0,  3'd5},
        {8'd143, 3'd3, 5'd0,  3'd0}, {8'd148, 3'd5, 5'd0,  3'd5},
        {8'd239, 3'd3, 5'd0,  3'd0}, {8'd244, 3'd5, 5'd0,  3'd5},
        {8'd245, 3'd3, 5'd0,  3'd0}, {8'd250, 3'd5, 5'd0,  3'd5},
        {8'd253, 3'd2, 5'd0,  3'd0}, {8'd0,   3'd2, 5'd0,  3'd0},
        {8'd4,   3'd2, 5'd0,  3'd0}, {8'd5,   3'd6, 5'd0,  3'd0},
        {8'd8,   3'd6, 5'd0,  3'd3}, {8'd9,   3'd6, 5'd1,  3'd0},
        {8'd129, 3'd6, 5'd31, 3'd0}, {8'd132, 3'd6, 5'd31, 3'd3},
        {8'd149, 3'd0, 5'd0,  3'd0}, {8'd200, 3'd0, 5'd0,  3'd0},
        {8'd233, 3'd0, 5'd0,  3'd0}
    };

    task automatic step(input logic [7:0] s);
        @(negedge clk);
        hslot = s;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt [8];
        step(8'd10);
        step(8'd10);
        // R1: outputs after reset
        chk("R1 op", op, 0); chk("R1 col", col, 0); chk("R1 phase", phase, 0);
        chk("R1 hscroll", hscroll, 0); chk("R1 lbuf_clr", lbuf_clr, 0);
        chk("R1 tbuf_init", tbuf_init, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2-R6 slot map vectors
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18:11]);
            chk("R2-map op", op, VEC[i][10:8]);
            chk("R5-map col", col, VEC[i][7:3]);
            chk("R3-map phase", phase, VEC[i][2:0]);
        end

        // Full sweep: operation totals per the map (R2 R3 R4 R5 R6)
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        for (int s = 0; s < 256; s++) begin
            step(8'(s));
            cnt[op]++;
        end
        chk("R2 cpu count", cnt[1], 11);
        chk("R4 scan count", cnt[2], 8);
        chk("R3 xread count", cnt[3], 8);
        chk("R3 fetch count", cnt[4], 8);
        chk("R3 render count", cnt[5], 8);
        chk("R5 column count", cnt[6], 128);
        chk("R6 idle count", cnt[0], 85);

        // R7: plain latch
        scroll_lock = 1'b0; vcounter = 9'd3; xscroll = 8'h33;
        step(8'd252);
        chk("R7 latch", hscroll, 8'h33);
        // R9: xscroll changes ignored off the latch slot
        xscroll = 8'h77;
        step(8'd253); step(8'd0); step(8'd136);
        chk("R9 hold", hscroll, 8'h33);
        // R8: lock inside top rows
        scroll_lock = 1'b1; vcounter = 9'd15; xscroll = 8'h5A;
        step(8'd252);
        chk("R8 locked", hscroll, 0);
        // R8: lock ineffective at row 16
        vcounter = 9'd16;
        step(8'd252);
        chk("R8 boundary", hscroll, 8'h5A);

        // R10: line buffer clear pulse
        step(8'd135); chk("R10 before", lbuf_clr, 0);
        step(8'd136); chk("R10 pulse", lbuf_clr, 1);
        step(8'd137); chk("R10 after", lbuf_clr, 0);
        // R11: staging buffer init pulse
        step(8'd3); chk("R11 before", tbuf_init, 0);
        step(8'd4); chk("R11 pulse", tbuf_init, 1);
        step(8'd5); chk("R11 after", tbuf_init, 0);

        // R1: reset mid-run clears latched state
        @(negedge clk); rst_n = 1'b0;
        step(8'd136);
        chk("R1 rst hscroll", hscroll, 0);
        chk("R1 rst op", op, 0);
        chk("R1 rst lbuf_clr", lbuf_clr, 0);

        finish_run();
    end

endmodule